// File: doc/BRIEF.md
# DMA Interrupt Status Register

This block holds the interrupt status of a descriptor-driven DMA engine that moves data for a memory-card host controller. The DMA datapath reports single-cycle event pulses to it: a descriptor's transmit data finished, a descriptor's receive data completed, a fatal bus error with a three-bit cause, and a fetched descriptor that the engine does not own. Seven card error pulses from the card interface are also reported. Each event sets a status bit that software clears by writing 1 to it.

Two sticky summary bits gather the status bits. One covers the normal completions and one covers the abnormal conditions. Only the sources enabled in an interrupt-enable vector reach a summary. The block drives an interrupt whenever either summary bit is set. A fatal bus error also asserts a halt output, which stops all DMA bus traffic until software clears the error bit. The read word captures the cause of the bus error and shows the current state code of the DMA state machine.

Software reaches the block through a single-register port. A write strobe carries write data. The read data always shows the current register contents.

Top module: `dmac_irq_status`

## Requirements
- R1: After reset, all status bits, both summaries and the error type field read as 0, and `irq` and `dma_halt` are low.
- R2: A pulse on `ev_tx_done` sets bit 0 and a pulse on `ev_rx_done` sets bit 1, both visible on the next cycle. Writing 1 to a bit clears it, and writing 0 leaves it unchanged.
- R3: A pulse on `ev_bus_err` sets bit 2. `dma_halt` is high exactly while bit 2 is set.
- R4: A pulse on `ev_desc_unavail` (the fetched descriptor is not owned by the DMA) sets bit 4, and writing 1 clears it.
- R5: A pulse on any one of the seven `card_err` lines sets bit 5, the card error summary, and writing 1 clears it.
- R6: When a set event and a write-1 clear hit the same status or summary bit in the same cycle, the bit is set.
- R7: Bit 8 (normal summary) sets in the same cycle as bit 0 or bit 1 when the matching `irq_en` bit is 1. `irq_en[i]` enables status bit i. A masked source never sets bit 8.
- R8: Bit 9 (abnormal summary) sets in the same cycle as bit 2, 4 or 5 when the matching `irq_en` bit is 1. A masked source never sets it.
- R9: Both summary bits stay set after their sources clear, until 1 is written to them. Such a write does not clear a summary while an enabled source bit stays set. Writing 1 to a source and its summary together clears both.
- R10: Bits 12:10 take `ev_bus_err_type` on the cycle bit 2 goes from 0 to 1, hold that value while bit 2 stays set (even through later bus errors), and read 0 once bit 2 is clear.
- R11: Bits 16:13 show `dma_state` combinationally. The codes are 0 idle, 1 suspend, 2 descriptor read, 3 descriptor check, 4 read-request wait, 5 write-request wait, 6 read, 7 write, 8 descriptor close.
- R12: `irq` is high exactly when bit 8 or bit 9 is set.
- R13: Bits 3, 7:6 and 31:17 always read 0, and writes to them have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ev_tx_done | input | 1 | Pulse: transmit data of one descriptor finished |
| ev_rx_done | input | 1 | Pulse: receive data into one descriptor completed |
| ev_bus_err | input | 1 | Pulse: fatal bus error |
| ev_bus_err_type | input | 3 | Cause of the bus error (1 abort in transmit, 2 abort in receive) |
| ev_desc_unavail | input | 1 | Pulse: fetched descriptor not owned by the DMA |
| card_err | input | 7 | Card error pulses, one per error kind |
| irq_en | input | 6 | Enable per status bit 5:0 for the summaries |
| dma_state | input | 4 | Current DMA state code |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data (1 clears a bit) |
| reg_rdata | output | 32 | Register read data |
| irq | output | 1 | Interrupt request |
| dma_halt | output | 1 | Blocks all DMA bus accesses |

## Verification
Every status bit, summary bit and the error type field is registered. A pulse or write presented in one cycle therefore appears in `reg_rdata`, `irq` and `dma_halt` exactly one clock edge later. The state field is combinational and shows a new `dma_state` in the same cycle. The bench drives inputs on the falling edge and samples one falling edge later, after exactly one rising edge, for the registered results. It samples the state field a nanosecond after changing `dma_state`, with no clock edge in between.

// File: rtl/dmac_irq_pkg.sv
package dmac_irq_pkg;
   localparam int REG_W    = 32;
   localparam int SRC_N    = 6;
   localparam int B_TX     = 0;
   localparam int B_RX     = 1;
   localparam int B_BERR   = 2;
   localparam int B_DU     = 4;
   localparam int B_CES    = 5;
   localparam int B_NORM   = 8;
   localparam int B_ABN    = 9;
   localparam int B_EB_LO  = 10;
   localparam int B_ST_LO  = 13;

   // Which of the low status positions hold a real bit
   localparam logic [SRC_N-1:0] SRC_USED = 6'b110111;
   localparam logic [SRC_N-1:0] NORM_SEL = 6'b000011;
   localparam logic [SRC_N-1:0] ABN_SEL  = 6'b110100;

   typedef enum logic [3:0] {
      ST_IDLE       = 4'd0,
      ST_SUSPEND    = 4'd1,
      ST_DESC_RD    = 4'd2,
      ST_DESC_CHK   = 4'd3,
      ST_RDREQ_WAIT = 4'd4,
      ST_WRREQ_WAIT = 4'd5,
      ST_RD         = 4'd6,
      ST_WR         = 4'd7,
      ST_DESC_CLOSE = 4'd8
   } dma_state_e;
endpackage

// File: rtl/dis_stat_bit.sv
// One write-1-to-clear status cell; a set in the same cycle beats the clear.
module dis_stat_bit (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic clr_i,
   output logic q_o,
   output logic d_o
);
   logic q;

   assign d_o = set_i | (q & ~clr_i);
   assign q_o = q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= 1'b0;
      else        q <= d_o;
   end
endmodule

// File: rtl/dis_summary.sv
// Sticky OR of the enabled sources, fed from their next-state values.
module dis_summary #(
   parameter int N = 6
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] src_next,
   input  logic [N-1:0] en,
   input  logic         clr,
   output logic         q
);
   logic hit;
   logic d_unused;

   generate
      if (N < 1) begin : g_bad
         $error("dis_summary: N must be at least 1");
      end
   endgenerate

   assign hit = |(src_next & en);

   dis_stat_bit u_cell (
      .clk   (clk),
      .rst_n (rst_n),
      .set_i (hit),
      .clr_i (clr),
      .q_o   (q),
      .d_o   (d_unused)
   );
endmodule

// File: rtl/dis_err_capture.sv
// Holds the bus error cause from the first setting of the error bit
// until that bit clears.
module dis_err_capture #(
   parameter int W = 3
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         first_set,
   input  logic         keep,
   input  logic [W-1:0] code_in,
   output logic [W-1:0] code
);
   generate
      if (W < 1) begin : g_bad
         $error("dis_err_capture: W must be at least 1");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         code <= '0;
      else if (!keep)     code <= '0;
      else if (first_set) code <= code_in;
   end
endmodule

// File: rtl/dmac_irq_status.sv
module dmac_irq_status #(
   parameter int CARD_ERR_W = 7,
   parameter int ERR_TYPE_W = 3,
   parameter int STATE_W    = 4
) (
   input  logic                                 clk,
   input  logic                                 rst_n,
   input  logic                                 ev_tx_done,
   input  logic                                 ev_rx_done,
   input  logic                                 ev_bus_err,
   input  logic [ERR_TYPE_W-1:0]                ev_bus_err_type,
   input  logic                                 ev_desc_unavail,
   input  logic [CARD_ERR_W-1:0]                card_err,
   input  logic [dmac_irq_pkg::SRC_N-1:0]       irq_en,
   input  logic [STATE_W-1:0]                   dma_state,
   input  logic                                 reg_wr,
   input  logic [dmac_irq_pkg::REG_W-1:0]       reg_wdata,
   output logic [dmac_irq_pkg::REG_W-1:0]       reg_rdata,
   output logic                                 irq,
   output logic                                 dma_halt
);
   import dmac_irq_pkg::*;

   localparam int EB_HI = B_EB_LO + ERR_TYPE_W - 1;
   localparam int ST_HI = B_ST_LO + STATE_W - 1;

   generate
      if (EB_HI >= B_ST_LO) begin : g_bad_eb
         $error("dmac_irq_status: error type field overlaps state field");
      end
      if (ST_HI >= REG_W) begin : g_bad_st
         $error("dmac_irq_status: state field exceeds register width");
      end
      if (CARD_ERR_W < 1) begin : g_bad_ce
         $error("dmac_irq_status: need at least one card error line");
      end
   endgenerate

   logic [SRC_N-1:0]      set_vec;
   logic [SRC_N-1:0]      clr_vec;
   logic [SRC_N-1:0]      stat_q;
   logic [SRC_N-1:0]      stat_d;
   logic                  card_any;
   logic                  norm_q;
   logic                  abn_q;
   logic [ERR_TYPE_W-1:0] eb_q;
   logic                  unused_bits;

   assign card_any = |card_err;

   always_comb begin
      set_vec         = '0;
      set_vec[B_TX]   = ev_tx_done;
      set_vec[B_RX]   = ev_rx_done;
      set_vec[B_BERR] = ev_bus_err;
      set_vec[B_DU]   = ev_desc_unavail;
      set_vec[B_CES]  = card_any;
   end

   assign clr_vec = reg_wr ? reg_wdata[SRC_N-1:0] : '0;

   generate
      for (genvar i = 0; i < SRC_N; i++) begin : g_src
         if (SRC_USED[i]) begin : g_cell
            dis_stat_bit u_bit (
               .clk   (clk),
               .rst_n (rst_n),
               .set_i (set_vec[i]),
               .clr_i (clr_vec[i]),
               .q_o   (stat_q[i]),
               .d_o   (stat_d[i])
            );
         end else begin : g_rsvd
            assign stat_q[i] = 1'b0;
            assign stat_d[i] = 1'b0;
         end
      end
   endgenerate

   dis_summary #(.N(SRC_N)) u_norm (
      .clk      (clk),
      .rst_n    (rst_n),
      .src_next (stat_d),
      .en       (irq_en & NORM_SEL),
      .clr      (reg_wr & reg_wdata[B_NORM]),
      .q        (norm_q)
   );

   dis_summary #(.N(SRC_N)) u_abn (
      .clk      (clk),
      .rst_n    (rst_n),
      .src_next (stat_d),
      .en       (irq_en & ABN_SEL),
      .clr      (reg_wr & reg_wdata[B_ABN]),
      .q        (abn_q)
   );

   dis_err_capture #(.W(ERR_TYPE_W)) u_eb (
      .clk       (clk),
      .rst_n     (rst_n),
      .first_set (stat_d[B_BERR] & ~stat_q[B_BERR]),
      .keep      (stat_d[B_BERR]),
      .code_in   (ev_bus_err_type),
      .code      (eb_q)
   );

   always_comb begin
      reg_rdata                   = '0;
      reg_rdata[SRC_N-1:0]        = stat_q;
      reg_rdata[B_NORM]           = norm_q;
      reg_rdata[B_ABN]            = abn_q;
      reg_rdata[EB_HI:B_EB_LO]    = eb_q;
      reg_rdata[ST_HI:B_ST_LO]    = dma_state;
   end

   assign irq      = norm_q | abn_q;
   assign dma_halt = stat_q[B_BERR];

   assign unused_bits = ^{reg_wdata[REG_W-1:B_ABN+1], reg_wdata[B_NORM-1:SRC_N],
                          clr_vec[3], set_vec[3]};
endmodule

// File: rtl/dmac_irq_status_chk.sv
module dmac_irq_status_chk (
   input logic        clk,
   input logic        rst_n,
   input logic        ev_tx_done,
   input logic        ev_rx_done,
   input logic        ev_bus_err,
   input logic [5:0]  irq_en,
   input logic        reg_wr,
   input logic [31:0] reg_wdata,
   input logic [31:0] reg_rdata,
   input logic        irq,
   input logic        dma_halt
);
   // R2: a transmit completion shows in bit 0 one cycle later
   a_r2_tx_sets: assert property (@(posedge clk) disable iff (!rst_n)
      ev_tx_done |=> reg_rdata[0]);

   // R3: a bus error raises the halt on the next cycle
   a_r3_halt_on_err: assert property (@(posedge clk) disable iff (!rst_n)
      ev_bus_err |=> dma_halt);

   // R6: a receive event beats a same-cycle clear
   a_r6_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
      (ev_rx_done && reg_wr && reg_wdata[1]) |=> reg_rdata[1]);

   // R7: with both normal sources masked, the normal summary cannot rise
   a_r7_norm_masked: assert property (@(posedge clk) disable iff (!rst_n)
      (!reg_rdata[8] && !irq_en[0] && !irq_en[1]) |=> !reg_rdata[8]);

   // R9: the normal summary stays set unless written with 1
   a_r9_norm_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_rdata[8] && !(reg_wr && reg_wdata[8])) |=> reg_rdata[8]);

   // R10: the error type holds while the bus error bit is not cleared
   a_r10_eb_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_rdata[2] && !(reg_wr && reg_wdata[2])) |=> $stable(reg_rdata[12:10]));

   // R12: the interrupt follows the two summaries
   a_r12_irq: assert property (@(posedge clk) disable iff (!rst_n)
      irq == (reg_rdata[8] || reg_rdata[9]));
endmodule

bind dmac_irq_status dmac_irq_status_chk u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .ev_tx_done (ev_tx_done),
   .ev_rx_done (ev_rx_done),
   .ev_bus_err (ev_bus_err),
   .irq_en     (irq_en),
   .reg_wr     (reg_wr),
   .reg_wdata  (reg_wdata),
   .reg_rdata  (reg_rdata),
   .irq        (irq),
   .dma_halt   (dma_halt)
);

// File: tb/dmac_irq_status_bench.sv
`timescale 1ns/1ps
module dmac_irq_status_bench;
   logic        clk = 1'b0;
   logic        rst_n;
   logic        ev_tx_done, ev_rx_done, ev_bus_err, ev_desc_unavail;
   logic [2:0]  ev_bus_err_type;
   logic [6:0]  card_err;
   logic [5:0]  irq_en;
   logic [3:0]  dma_state;
   logic        reg_wr;
   logic [31:0] reg_wdata;
   logic [31:0] reg_rdata;
   logic        irq, dma_halt;

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   always #2.5 clk = ~clk;

   dmac_irq_status u_dmac_irq_status (
      .clk(clk), .rst_n(rst_n),
      .ev_tx_done(ev_tx_done), .ev_rx_done(ev_rx_done),
      .ev_bus_err(ev_bus_err), .ev_bus_err_type(ev_bus_err_type),
      .ev_desc_unavail(ev_desc_unavail), .card_err(card_err),
      .irq_en(irq_en), .dma_state(dma_state),
      .reg_wr(reg_wr), .reg_wdata(reg_wdata),
      .reg_rdata(reg_rdata), .irq(irq), .dma_halt(dma_halt)
   );

   // {tx,rx,berr,btype[3],du,card[7],wr,wdata[32],en[6],st[4],exp_rdata[32],exp_irq,exp_halt}
   localparam int NV = 18;
   localparam logic [90:0] VEC [NV] = '{
      {3'b100,3'd0,1'b0,7'd0,1'b0,32'h0,6'h37,4'd2,32'h0000_4101,1'b1,1'b0},        // R2 R7 tx sets bit0 and normal summary
      {3'b000,3'd0,1'b0,7'd0,1'b1,32'h1,6'h37,4'd3,32'h0000_6100,1'b1,1'b0},        // R9 source cleared, summary sticky
      {3'b000,3'd0,1'b0,7'd0,1'b1,32'h100,6'h37,4'd0,32'h0,1'b0,1'b0},              // R9 R12 summary cleared, irq low
      {3'b010,3'd0,1'b0,7'd0,1'b1,32'h2,6'h37,4'd0,32'h0000_0102,1'b1,1'b0},        // R6 rx set beats clear
      {3'b000,3'd0,1'b0,7'd0,1'b1,32'h102,6'h37,4'd0,32'h0,1'b0,1'b0},              // R9 source and summary cleared together
      {3'b100,3'd0,1'b0,7'd0,1'b0,32'h0,6'h00,4'd0,32'h0000_0001,1'b0,1'b0},        // R7 masked tx: no summary
      {3'b000,3'd0,1'b0,7'd0,1'b1,32'h1,6'h00,4'd0,32'h0,1'b0,1'b0},                // R2 write-1 clears bit0
      {3'b001,3'd2,1'b0,7'd0,1'b0,32'h0,6'h37,4'd6,32'h0000_CA04,1'b1,1'b1},        // R3 R8 R10 bus error, type 2 captured
      {3'b001,3'd1,1'b0,7'd0,1'b0,32'h0,6'h37,4'd6,32'h0000_CA04,1'b1,1'b1},        // R10 second bus error keeps type 2
      {3'b000,3'd0,1'b0,7'd0,1'b1,32'h4,6'h37,4'd6,32'h0000_C200,1'b1,1'b0},        // R3 R10 clear: halt off, type 0
      {3'b000,3'd0,1'b0,7'd0,1'b1,32'h200,6'h37,4'd6,32'h0000_C000,1'b0,1'b0},      // R9 abnormal summary cleared
      {3'b000,3'd0,1'b1,7'd0,1'b0,32'h0,6'h37,4'd1,32'h0000_2210,1'b1,1'b0},        // R4 R8 descriptor unavailable
      {3'b000,3'd0,1'b0,7'd0,1'b1,32'h200,6'h37,4'd1,32'h0000_2210,1'b1,1'b0},      // R9 summary stays while source set
      {3'b000,3'd0,1'b0,7'd0,1'b1,32'h210,6'h37,4'd0,32'h0,1'b0,1'b0},              // R4 clear both
      {3'b000,3'd0,1'b0,7'h40,1'b0,32'h0,6'h37,4'd0,32'h0000_0220,1'b1,1'b0},       // R5 R8 top card error line
      {3'b000,3'd0,1'b0,7'd0,1'b1,32'h220,6'h37,4'd0,32'h0,1'b0,1'b0},              // R5 clear
      {3'b000,3'd0,1'b0,7'h01,1'b0,32'h0,6'h10,4'd0,32'h0000_0020,1'b0,1'b0},       // R5 R8 masked card error
      {3'b000,3'd0,1'b0,7'd0,1'b1,32'hFFFF_FFFF,6'h37,4'd8,32'h0001_0000,1'b0,1'b0} // R13 writes to reserved bits ignored
   };

   task automatic check32(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: got %h expected %h", tag, act, exp);
      end
   endtask

   task automatic idle_inputs();
      ev_tx_done = 0; ev_rx_done = 0; ev_bus_err = 0; ev_bus_err_type = 0;
      ev_desc_unavail = 0; card_err = 0; reg_wr = 0; reg_wdata = 0;
   endtask

   task automatic step();
      @(posedge clk);
      @(negedge clk);
      idle_inputs();
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin : main
      rst_n = 1'b0;
      idle_inputs();
      irq_en = 6'h37;
      dma_state = 4'd0;
      repeat (3) @(negedge clk);
      // R1: reset state
      check32("R1 reset rdata", reg_rdata, 32'h0);
      check32("R1 reset irq/halt", {30'd0, irq, dma_halt}, 32'h0);
      rst_n = 1'b1;
      @(negedge clk);

      for (int v = 0; v < NV; v++) begin
         {ev_tx_done, ev_rx_done, ev_bus_err} = VEC[v][90:88];
         ev_bus_err_type = VEC[v][87:85];
         ev_desc_unavail = VEC[v][84];
         card_err        = VEC[v][83:77];
         reg_wr          = VEC[v][76];
         reg_wdata       = VEC[v][75:44];
         irq_en          = VEC[v][43:38];
         dma_state       = VEC[v][37:34];
         @(posedge clk);
         @(negedge clk);
         check32($sformatf("table vector %0d rdata", v), reg_rdata, VEC[v][33:2]);
         check32($sformatf("table vector %0d irq/halt R12 R3", v),
                 {30'd0, irq, dma_halt}, {30'd0, VEC[v][1:0]});
         idle_inputs();
      end
      dma_state = 4'd0;
      irq_en    = 6'h00;

      // R5: each card error line alone sets bit 5
      for (int i = 0; i < 7; i++) begin
         card_err = 7'(1 << i);
         step();
         check32($sformatf("R5 card line %0d", i), reg_rdata, 32'h20);
         reg_wr = 1; reg_wdata = 32'h20;
         step();
         check32($sformatf("R5 card line %0d clear", i), reg_rdata, 32'h0);
      end

      // R10: fresh bus error after clearing captures the new type
      ev_bus_err = 1; ev_bus_err_type = 3'd1;
      step();
      check32("R10 new type captured", reg_rdata, 32'h0000_0404);
      check32("R3 halt with masked error", {31'd0, dma_halt}, 32'h1);
      reg_wr = 1; reg_wdata = 32'h4;
      step();
      check32("R10 type cleared with bit2", reg_rdata, 32'h0);

      // R11: state field is combinational
      dma_state = 4'd7;
      #1;
      check32("R11 state write", reg_rdata, 32'h0000_E000);
      dma_state = 4'd5;
      #1;
      check32("R11 state wr-req wait", reg_rdata, 32'h0000_A000);
      dma_state = 4'd0;
      @(negedge clk);

      // R1: reset in mid-run clears everything
      irq_en = 6'h37;
      ev_tx_done = 1; ev_bus_err = 1; ev_bus_err_type = 3'd2;
      step();
      check32("R1 pre-reset state", reg_rdata, 32'h0000_0B05);
      rst_n = 1'b0;
      #1;
      check32("R1 mid-run reset rdata", reg_rdata, 32'h0);
      check32("R1 mid-run reset irq/halt", {30'd0, irq, dma_halt}, 32'h0);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule